// File: doc/BRIEF.md
# PLL Control and Status Register Block

This block holds the software-visible controls of a clock-multiplier PLL. The controls are the PLL enable, the selection of the VCO clock as the base clock, the interrupt enable, the automatic-bandwidth mode and a 4-bit VCO range multiplier. The block also reports lock status and a lock-change flag. Software reaches it through a small register bus. A write takes effect at the clock edge on which the write strobe is sampled. Read data is combinational from the current state while the read strobe is high.

The block enforces interlocks between its fields. The range multiplier is frozen while the PLL runs. A zero range keeps the PLL off and blocks VCO clock selection. The lock status input comes from the analog loop and passes through a synchronizer. Each change of the synchronized value, in either direction, sets a flag when automatic mode is on. That flag can raise an interrupt. The block has no streaming data path, so every pin is a plain level signal with no valid/ready handshake.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x00 and address 2 reads 0x06. The outputs pll_enable, vco_sel, auto_bw and pll_irq are 0, and vco_range is 6.
- R2: Register map. Address 0 holds flag in bit 7 (read-only), interrupt enable in bit 6, PLL enable in bit 5 and base-clock select in bit 4. Address 1 holds auto mode in bit 7 and synchronized lock in bit 6 (read-only). Address 2 holds the range in bits 3:0. Unused bits and address 3 read 0.
- R3: A write to address 2 is ignored while the PLL enable bit is 1.
- R4: A write that sets base-clock select is ignored while the range is 0.
- R5: Writing range 0 clears base-clock select. While the range is 0, a write that sets PLL enable is ignored.
- R6: The vco_sel output is 1 only when both base-clock select and PLL enable are 1.
- R7: With auto mode 1, each rising and each falling change of lock_in sets the flag, whatever the interrupt enable holds. The lock bit follows lock_in after two clocks. The flag reads 1 from the third clock after the change.
- R8: With auto mode 0, lock changes raise no interrupt and the flag reads 0.
- R9: pll_irq is 1 exactly when the flag reads 1 and the interrupt enable is 1.
- R10: A read of address 0 that returns the flag as 1 clears it. If a lock change is detected in the same cycle as that read, the flag stays set.
- R11: Bus writes do not change the flag or the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| lock_in | input | 1 | Asynchronous lock status from the PLL |
| pll_irq | output | 1 | Lock-change interrupt request |
| pll_enable | output | 1 | PLL power/enable |
| vco_sel | output | 1 | Select VCO clock as base clock |
| vco_range | output | 4 | VCO range multiplier |
| auto_bw | output | 1 | Automatic bandwidth mode |

## Verification
The lock input is driven with a rising and a falling change. This separates edge detection from level detection, and shows that the flag does not depend on the interrupt enable. Lock changes are repeated with auto mode off, which shows that auto mode alone gates the flag. A flag-clearing read is placed on the same cycle as a new lock change, which tests the set-over-clear priority. Range writes are tried with the PLL on and off, and with a value of zero, followed by attempts to set the enable and select bits. These attempts tell the separate interlocks apart.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int RANGE_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RANGE = 2'd2;

  localparam int B_FLAG  = 7;
  localparam int B_IRQEN = 6;
  localparam int B_PLLON = 5;
  localparam int B_BSEL  = 4;
  localparam int B_AUTO  = 7;
  localparam int B_LOCK  = 6;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic change
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign sync_out = chain_q[STAGES-1];
  assign change   = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pll_ctl_fields.sv
module pll_ctl_fields #(
  parameter int                  RANGE_W   = 4,
  parameter logic [RANGE_W-1:0]  RANGE_RST = 4'd6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_mode,
  input  logic               wr_range,
  input  logic               wd_irq_en,
  input  logic               wd_pll_on,
  input  logic               wd_bsel,
  input  logic               wd_auto,
  input  logic [RANGE_W-1:0] wd_range,
  output logic               irq_en_q,
  output logic               pll_on_q,
  output logic               bsel_q,
  output logic               auto_q,
  output logic [RANGE_W-1:0] range_q
);
  logic range_zero;
  assign range_zero = (range_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      pll_on_q <= 1'b0;
      bsel_q   <= 1'b0;
      auto_q   <= 1'b0;
      range_q  <= RANGE_RST;
    end else begin
      if (wr_ctrl) begin
        irq_en_q <= wd_irq_en;
        pll_on_q <= wd_pll_on & ~range_zero;
        bsel_q   <= wd_bsel   & ~range_zero;
      end
      if (wr_mode) auto_q <= wd_auto;
      if (wr_range && !pll_on_q) begin
        range_q <= wd_range;
        if (wd_range == '0) begin
          bsel_q   <= 1'b0;
          pll_on_q <= 1'b0;
        end
      end
    end
  end

  a_r3_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on_q |=> $stable(range_q));
  a_r4_no_select_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (range_zero && !bsel_q) |=> !bsel_q);
  a_r5_zero_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    range_zero |-> (!pll_on_q && !bsel_q));
endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic change,
  input  logic auto_q,
  input  logic irq_en_q,
  input  logic rd_clr,
  output logic flag_vis,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (!auto_q) flag_q <= 1'b0;
    else if (change)  flag_q <= 1'b1;
    else if (rd_clr)  flag_q <= 1'b0;
  end

  assign flag_vis = flag_q & auto_q;
  assign irq      = flag_vis & irq_en_q;

  a_r7_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && change) |=> flag_q);
  a_r8_manual_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |=> !flag_q);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !change && auto_q) |=> !flag_q);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (auto_q && irq_en_q));
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RANGE_RESET = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               lock_in,
  output logic               pll_irq,
  output logic               pll_enable,
  output logic               vco_sel,
  output logic [RANGE_W-1:0] vco_range,
  output logic               auto_bw
);
  localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(RANGE_RESET);

  logic lock_s, change, flag_vis, rd_clr;
  logic irq_en_q, pll_on_q, bsel_q, auto_q;
  logic [RANGE_W-1:0] range_q;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(lock_in),
    .sync_out(lock_s), .change(change)
  );

  pll_ctl_fields #(.RANGE_W(RANGE_W), .RANGE_RST(RANGE_RST)) u_fields (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl (bus_wr && bus_addr == A_CTRL),
    .wr_mode (bus_wr && bus_addr == A_MODE),
    .wr_range(bus_wr && bus_addr == A_RANGE),
    .wd_irq_en(bus_wdata[B_IRQEN]),
    .wd_pll_on(bus_wdata[B_PLLON]),
    .wd_bsel  (bus_wdata[B_BSEL]),
    .wd_auto  (bus_wdata[B_AUTO]),
    .wd_range (bus_wdata[RANGE_W-1:0]),
    .irq_en_q(irq_en_q), .pll_on_q(pll_on_q), .bsel_q(bsel_q),
    .auto_q(auto_q), .range_q(range_q)
  );

  assign rd_clr = bus_rd && (bus_addr == A_CTRL) && flag_vis;

  pll_lock_irq u_irq (
    .clk(clk), .rst_n(rst_n), .change(change), .auto_q(auto_q),
    .irq_en_q(irq_en_q), .rd_clr(rd_clr),
    .flag_vis(flag_vis), .irq(pll_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[B_FLAG]  = flag_vis;
          bus_rdata[B_IRQEN] = irq_en_q;
          bus_rdata[B_PLLON] = pll_on_q;
          bus_rdata[B_BSEL]  = bsel_q;
        end
        A_MODE: begin
          bus_rdata[B_AUTO] = auto_q;
          bus_rdata[B_LOCK] = lock_s;
        end
        A_RANGE: bus_rdata[RANGE_W-1:0] = range_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pll_enable = pll_on_q;
  assign vco_sel    = bsel_q & pll_on_q;
  assign vco_range  = range_q;
  assign auto_bw    = auto_q;

  a_r6_select_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    vco_sel |-> (pll_enable && vco_range != '0));
  a_r11_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_MODE) |-> (bus_rdata[B_LOCK] == lock_s));
endmodule

// File: tb/test_pll_ctl_regs.sv
module test_pll_ctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lock_in = 1'b0;
  logic       pll_irq, pll_enable, vco_sel, auto_bw;
  logic [3:0] vco_range;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pll_ctl_regs i_pll_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_in(lock_in), .pll_irq(pll_irq), .pll_enable(pll_enable),
    .vco_sel(vco_sel), .vco_range(vco_range), .auto_bw(auto_bw)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 mode", d, 8'h00);
    rd(2'd2, d); check("R1 range", d, 8'h06);
    check("R1 outs", {pll_enable, vco_sel, auto_bw, pll_irq, vco_range}, 8'h06);
    rd(2'd3, d); check("R2 addr3", d, 8'h00);
  endtask

  task automatic t_interlock;
    logic [7:0] d;
    wr(2'd2, 8'hF9); rd(2'd2, d); check("R2 range bits", d, 8'h09);
    wr(2'd0, 8'h30); rd(2'd0, d); check("R2 ctrl bits", d, 8'h30);
    check("R6 sel on", {7'd0, vco_sel}, 8'h01);
    wr(2'd2, 8'h03); rd(2'd2, d); check("R3 frozen", d, 8'h09);
    wr(2'd0, 8'h10); check("R6 sel off w/o enable", {7'd0, vco_sel}, 8'h00);
    wr(2'd2, 8'h03); rd(2'd2, d); check("R3 writable when off", d, 8'h03);
    wr(2'd2, 8'h00); rd(2'd0, d); check("R5 zero clears sel", d, 8'h00);
    wr(2'd0, 8'h30); rd(2'd0, d); check("R4 R5 blocked at zero", d, 8'h00);
    check("R5 enable pin", {7'd0, pll_enable}, 8'h00);
    wr(2'd2, 8'h06); wr(2'd0, 8'h00);
  endtask

  task automatic t_auto_edges;
    logic [7:0] d;
    wr(2'd1, 8'h80); check("R2 auto pin", {7'd0, auto_bw}, 8'h01);
    @(negedge clk); lock_in = 1'b1;
    settle(2); rd(2'd1, d); check("R7 lock bit", d, 8'hC0);
    rd(2'd0, d); check("R7 flag on rise", d, 8'h80);
    rd(2'd0, d); check("R10 cleared by read", d, 8'h00);
    wr(2'd0, 8'h40);
    @(negedge clk); lock_in = 1'b0;
    settle(3); check("R9 irq", {7'd0, pll_irq}, 8'h01);
    rd(2'd1, d); check("R7 lock low", d, 8'h80);
    wr(2'd0, 8'h40); rd(2'd0, d); check("R11 flag kept by write", d, 8'hC0);
    rd(2'd0, d);
    wr(2'd0, 8'hC0); rd(2'd0, d); check("R11 flag not set by write", d, 8'h40);
    check("R9 irq low", {7'd0, pll_irq}, 8'h00);
    wr(2'd1, 8'hC0); rd(2'd1, d); check("R11 lock not written", d, 8'h80);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    @(negedge clk); lock_in = 1'b1;
    settle(4);
    lock_in = 1'b0;
    settle(2);
    bus_addr = 2'd0; bus_rd = 1'b1;
    #1 d = bus_rdata; check("R10 flag before race", d, 8'hC0);
    @(negedge clk); bus_rd = 1'b0;
    rd(2'd0, d); check("R10 set wins over clear", d, 8'hC0);
    rd(2'd0, d); check("R10 then clears", d, 8'h40);
  endtask

  task automatic t_manual;
    logic [7:0] d;
    wr(2'd1, 8'h00);
    @(negedge clk); lock_in = 1'b1;
    settle(4);
    rd(2'd0, d); check("R8 no flag", d, 8'h40);
    check("R8 no irq", {7'd0, pll_irq}, 8'h00);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    t_reset();
    t_interlock();
    t_auto_edges();
    t_priority();
    t_manual();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule